// File: doc/BRIEF.md
# Edge Interrupt Source Gate

This block collects up to eight edge-triggered interrupt sources behind a single byte-wide register on a simple register bus. A bus write at the register's address loads the source enable mask. A bus read at the same address returns which enabled sources are pending. A single request line stays high while any pending flag is set.

Each source input passes through a synchronizer. After that, a rising edge on a source whose enable bit is set raises that source's pending flag. A pending flag is never cleared by a read. It clears only when software writes the mask with that source's bit at 0. A service routine therefore reads the status, writes the mask with the triggered bits cleared, reads again until the status is zero, and then restores the mask. A parameter lists which sources are physically present. Absent sources can never be enabled and always read as 0.

Top module: `irq_src_ctrl`

## Requirements
- R1: After reset the enable mask and every pending flag are 0, `irq_o` is 0 and `rdata_o` is 0.
- R2: A write with `addr_i` equal to `REG_ADDR` (default 0x1E) loads the enable mask from `wdata_i`. Bit n enables source n. Only sources whose bit is set in the mask can become pending.
- R3: A rising edge on an enabled source sets its pending flag three clock edges after the input rises (two synchronizer stages plus the flag register). A source held high does not trigger again.
- R4: An edge that arrives while the source's enable bit is 0 is not recorded. Enabling the source later shows no pending flag for it.
- R5: A pending flag stays set while its enable bit stays 1, even after the source input falls.
- R6: Writing the mask with a source's bit at 0 clears that source's pending flag. Writing the bit back to 1 does not restore the flag.
- R7: `irq_o` is 1 exactly when at least one pending flag is set. It drops once every triggered source has been masked.
- R8: Bits outside `VALID_MASK` (default 0x7F, so bit 7 is absent) never become pending and always read as 0, even when written as 1.
- R9: A read with `addr_i` equal to `REG_ADDR` places the pending flags on `rdata_o` after the next clock edge. Bit n is source n. At any other time `rdata_o` is 0. A read does not change any pending flag.
- R10: A write to any address other than `REG_ADDR` changes neither the mask nor the pending flags.
- R11: Writing 0 to the register disables every source and clears every pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_SRC | Asynchronous interrupt source inputs |
| addr_i | input | ADDR_W | Register bus byte address |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| wdata_i | input | NUM_SRC | Write data (enable mask) |
| rdata_o | output | NUM_SRC | Registered read data (pending flags) |
| irq_o | output | 1 | Interrupt request, high while any flag is pending |

## Verification
Suppose an enable bit or a pending flag is corrupted inside the block. This shows at the ports within one cycle: `irq_o` changes, and the next status read returns a wrong bit. If a mask write fails to clear a flag, the read right after the write still returns that flag, and `irq_o` stays high. If the edge detector fires on a level, or on a disabled source, a flag appears when the source is merely unmasked. The bench therefore reads the status right after each mask write and each source transition.

// File: rtl/irq_src_pkg.sv
package irq_src_pkg;

  typedef struct packed {
    logic wr_hit;
    logic rd_hit;
  } reg_hit_t;

  function automatic reg_hit_t decode_hit(input logic addr_match, input logic wr,
                                          input logic rd);
    reg_hit_t h;
    h.wr_hit = addr_match & wr;
    h.rd_hit = addr_match & rd;
    return h;
  endfunction

endpackage

// File: rtl/irq_src_sync.sv
module irq_src_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  generate
    if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
    end else begin : g_chain
      logic [WIDTH-1:0] stage_q [STAGES];
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
          stage_q[0] <= d_i;
          for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
      end
      assign q_o = stage_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/irq_src_edge.sv
module irq_src_edge #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] lvl_i,
  output logic [WIDTH-1:0] rise_o
);

  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;

endmodule

// File: rtl/irq_src_pend.sv
module irq_src_pend #(
  parameter int unsigned         WIDTH      = 8,
  parameter logic [WIDTH-1:0]    VALID_MASK = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] rise_i,
  input  logic             wr_hit_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] en_o,
  output logic [WIDTH-1:0] pend_o
);

  logic [WIDTH-1:0] en_q, en_d;
  logic [WIDTH-1:0] pend_q, pend_d;

  always_comb begin
    en_d   = wr_hit_i ? (wdata_i & VALID_MASK) : en_q;
    // new edges qualify against the mask in force this cycle; a cleared bit wins
    pend_d = (pend_q | (rise_i & en_q)) & en_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      pend_q <= '0;
    end else begin
      en_q   <= en_d;
      pend_q <= pend_d;
    end
  end

  assign en_o   = en_q;
  assign pend_o = pend_q;

endmodule

// File: rtl/irq_src_ctrl.sv
module irq_src_ctrl
  import irq_src_pkg::*;
#(
  parameter int unsigned          NUM_SRC     = 8,
  parameter int unsigned          ADDR_W      = 5,
  parameter logic [ADDR_W-1:0]    REG_ADDR    = 5'h1E,
  parameter logic [NUM_SRC-1:0]   VALID_MASK  = 8'h7F,
  parameter int unsigned          SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  output logic [NUM_SRC-1:0] rdata_o,
  output logic               irq_o
);

  logic [NUM_SRC-1:0] src_sync_w;
  logic [NUM_SRC-1:0] edge_w;
  logic [NUM_SRC-1:0] en_w;
  logic [NUM_SRC-1:0] pend_w;
  logic [NUM_SRC-1:0] rdata_q;
  reg_hit_t           hit_w;

  assign hit_w = decode_hit(addr_i == REG_ADDR, wr_en_i, rd_en_i);

  irq_src_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (src_i),
    .q_o   (src_sync_w)
  );

  irq_src_edge #(.WIDTH(NUM_SRC)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (src_sync_w),
    .rise_o(edge_w)
  );

  irq_src_pend #(.WIDTH(NUM_SRC), .VALID_MASK(VALID_MASK)) u_pend (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rise_i  (edge_w),
    .wr_hit_i(hit_w.wr_hit),
    .wdata_i (wdata_i),
    .en_o    (en_w),
    .pend_o  (pend_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           rdata_q <= '0;
    else if (hit_w.rd_hit) rdata_q <= pend_w & VALID_MASK;
    else                   rdata_q <= '0;
  end

  assign rdata_o = rdata_q;
  assign irq_o   = |pend_w;

endmodule

// File: rtl/irq_src_ctrl_chk.sv
module irq_src_ctrl_chk #(
  parameter int unsigned        NUM_SRC    = 8,
  parameter int unsigned        ADDR_W     = 5,
  parameter logic [ADDR_W-1:0]  REG_ADDR   = 5'h1E,
  parameter logic [NUM_SRC-1:0] VALID_MASK = 8'h7F
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [ADDR_W-1:0]  addr_i,
  input logic               wr_en_i,
  input logic               rd_en_i,
  input logic [NUM_SRC-1:0] wdata_i,
  input logic [NUM_SRC-1:0] rdata_o,
  input logic               irq_o,
  input logic [NUM_SRC-1:0] edge_w,
  input logic [NUM_SRC-1:0] en_w,
  input logic [NUM_SRC-1:0] pend_w
);

  AST_PEND_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_w & ~en_w) == '0); // R6

  AST_INVALID_NEVER_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_w & ~VALID_MASK) == '0); // R8

  AST_MASK_WRITE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == REG_ADDR) |=> (pend_w & ~$past(wdata_i)) == '0); // R11

  AST_NO_PEND_WITHOUT_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((edge_w & en_w) == '0) |=> (pend_w & ~$past(pend_w)) == '0); // R3

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> en_w != '0); // R7

  AST_IDLE_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_en_i && addr_i == REG_ADDR) |=> rdata_o == '0); // R9

endmodule

bind irq_src_ctrl irq_src_ctrl_chk #(
  .NUM_SRC   (NUM_SRC),
  .ADDR_W    (ADDR_W),
  .REG_ADDR  (REG_ADDR),
  .VALID_MASK(VALID_MASK)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .addr_i (addr_i),
  .wr_en_i(wr_en_i),
  .rd_en_i(rd_en_i),
  .wdata_i(wdata_i),
  .rdata_o(rdata_o),
  .irq_o  (irq_o),
  .edge_w (edge_w),
  .en_w   (en_w),
  .pend_w (pend_w)
);

// File: tb/irq_src_ctrl_test.sv
module irq_src_ctrl_test;

  localparam logic [4:0] REG = 5'h1E;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] src_i = '0;
  logic [4:0] addr_i = '0;
  logic       wr_en_i = 1'b0;
  logic       rd_en_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  irq_src_ctrl uut (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (src_i),
    .addr_i (addr_i),
    .wr_en_i(wr_en_i),
    .rd_en_i(rd_en_i),
    .wdata_i(wdata_i),
    .rdata_o(rdata_o),
    .irq_o  (irq_o)
  );

  always #4 clk_i = ~clk_i;

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic write_reg(logic [4:0] a, logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0; wdata_i = '0;
  endtask

  task automatic read_reg(logic [4:0] a, output logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; rd_en_i = 1'b1;
    @(negedge clk_i);
    d = rdata_o;
    rd_en_i = 1'b0;
  endtask

  task automatic set_src(logic [7:0] v);
    @(negedge clk_i);
    src_i = v;
    repeat (4) @(negedge clk_i);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    check("R1 rdata", rdata_o, 8'h00);
    check("R1 irq", {7'b0, irq_o}, 8'h00);
    read_reg(REG, d);
    check("R1 status", d, 8'h00);
  endtask

  task automatic t_basic;
    logic [7:0] d;
    write_reg(REG, 8'h7F);
    set_src(8'h01);
    check("R7 irq up", {7'b0, irq_o}, 8'h01);
    read_reg(REG, d);
    check("R3 status src0", d, 8'h01);
    set_src(8'h00);
    read_reg(REG, d);
    check("R5 hold after fall", d, 8'h01);
    read_reg(REG, d);
    check("R9 read non-destructive", d, 8'h01);
    set_src(8'h04);
    read_reg(REG, d);
    check("R3 second source", d, 8'h05);
  endtask

  task automatic t_service;
    logic [7:0] d;
    write_reg(REG, 8'h7F & ~8'h05);
    read_reg(REG, d);
    check("R6 cleared by mask", d, 8'h00);
    check("R7 irq drops", {7'b0, irq_o}, 8'h00);
    write_reg(REG, 8'h7F);
    read_reg(REG, d);
    check("R6 no restore", d, 8'h00);
    set_src(8'h00);
  endtask

  task automatic t_disabled;
    logic [7:0] d;
    write_reg(REG, 8'h00);
    set_src(8'h08);
    read_reg(REG, d);
    check("R4 disabled edge", d, 8'h00);
    write_reg(REG, 8'h7F);
    read_reg(REG, d);
    check("R4 not recorded", d, 8'h00);
    set_src(8'h00);
    write_reg(REG, 8'h01);
    set_src(8'h03);
    read_reg(REG, d);
    check("R2 only enabled src", d, 8'h01);
    set_src(8'h00);
    write_reg(REG, 8'h00);
    read_reg(REG, d);
    check("R11 zero clears", d, 8'h00);
    check("R11 irq low", {7'b0, irq_o}, 8'h00);
  endtask

  task automatic t_invalid;
    logic [7:0] d;
    write_reg(REG, 8'hFF);
    set_src(8'h80);
    read_reg(REG, d);
    check("R8 absent source", d, 8'h00);
    check("R8 irq low", {7'b0, irq_o}, 8'h00);
    set_src(8'h00);
  endtask

  task automatic t_other_addr;
    logic [7:0] d;
    write_reg(REG, 8'h7F);
    set_src(8'h10);
    write_reg(5'h1D, 8'h00);
    read_reg(REG, d);
    check("R10 foreign write ignored", d, 8'h10);
    read_reg(5'h00, d);
    check("R9 foreign read zero", d, 8'h00);
    set_src(8'h00);
    write_reg(REG, 8'h00);
  endtask

  task automatic t_level;
    logic [7:0] d;
    write_reg(REG, 8'h7F);
    set_src(8'h20);
    read_reg(REG, d);
    check("R3 level src5", d, 8'h20);
    write_reg(REG, 8'h5F);
    write_reg(REG, 8'h7F);
    read_reg(REG, d);
    check("R3 held level no retrigger", d, 8'h00);
    set_src(8'h00);
    set_src(8'h20);
    read_reg(REG, d);
    check("R3 new edge", d, 8'h20);
    write_reg(REG, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_basic();
    t_service();
    t_disabled();
    t_invalid();
    t_other_addr();
    t_level();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule